// File: doc/BRIEF.md
# Serial Channel Ready-Pin and Interrupt Generator

This block serves one serial channel. It keeps a transmit queue and a receive queue and turns their fill state into two active-low ready pins, which a DMA controller or a polling host watches. It also turns that fill state into a transmit and a receive interrupt request. The serial shifter pops the transmit queue and pushes the receive queue. The host pushes the transmit queue and pops the receive queue.

Three operating modes are chosen by a queue-enable bit and a DMA-mode bit. With queueing off, each direction behaves as a single holding register, and the DMA bit has no effect. With queueing on and DMA off, the ready pins report "anything there" (receive) and "completely drained" (transmit). With queueing on and DMA on, the ready pins become block handshakes. Transmit-ready stays low until the queue is full. Receive-ready falls when the queue reaches a programmed trigger level, or when a receive time-out strobe arrives. It then holds low until the queue is empty.

Top module: `uart_dma_handshake`

## Requirements
- R1: With queueing off (`fifo_en`=0), the receive side holds at most one byte. `rxrdy_n` is 0 and `rx_irq` is 1 exactly while that byte is held. `dma_mode` changes neither output.
- R2: With queueing off, the transmit side holds at most one byte. `txrdy_n` is 0 when it is empty and 1 when it holds the byte. A further write while the byte is held is dropped, and the count stays 1.
- R3: With queueing on and `dma_mode`=0, `rxrdy_n` is 0 whenever `rx_count` is at least 1, and 1 when `rx_count` is 0.
- R4: With queueing on and `dma_mode`=1, `rxrdy_n` goes to 0 in the same cycle that `rx_count` first reaches the trigger level. It stays 0 as bytes are read below that level, and returns to 1 in the cycle `rx_count` becomes 0.
- R5: With queueing on and `dma_mode`=1, a one-cycle `rx_timeout` pulse while the receive queue is non-empty drives `rxrdy_n` to 0 from the next clock edge, and it stays there until the queue is empty. A pulse while the queue is empty has no effect.
- R6: With queueing on and `dma_mode`=0, `txrdy_n` is 0 only while `tx_count` is 0.
- R7: With queueing on and `dma_mode`=1, `txrdy_n` is 0 while `tx_count` is below 16, and 1 at 16.
- R8: In every mode, `tx_irq` is 1 exactly when `tx_count` is 0.
- R9: With queueing on, `rx_irq` is 1 exactly when `rx_count` is at or above the trigger level. The level is chosen by `trig_sel` as follows: 0 gives 1, 1 gives 4, 2 gives 8, and 3 gives 14.
- R10: When `fifo_en` changes from 1 to 0, both counts are 0 after the next clock edge. The latched DMA receive-ready state is also dropped, so `rxrdy_n` reads 1.
- R11: A transmit write when the queue is at capacity, and a receive read when the queue is empty, leave the counts unchanged.
- R12: After reset, both counts are 0, `txrdy_n`=0, `rxrdy_n`=1, `tx_irq`=1 and `rx_irq`=0. Bytes leave each queue in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 enables 16-entry queueing, 0 gives single holding registers |
| dma_mode | input | 1 | 1 selects block handshake on ready pins (only with fifo_en=1) |
| trig_sel | input | 2 | Receive trigger level select: 1, 4, 8, 14 bytes |
| rx_timeout | input | 1 | One-cycle receive time-out strobe |
| tx_wr | input | 1 | Host pushes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte pushed by the host |
| tx_rd | input | 1 | Shifter pops the transmit queue |
| tx_rdata | output | 8 | Oldest transmit byte |
| rx_wr | input | 1 | Shifter pushes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_rd | input | 1 | Host pops the receive queue |
| rx_rdata | output | 8 | Oldest received byte |
| tx_count | output | 5 | Bytes held in the transmit queue |
| rx_count | output | 5 | Bytes held in the receive queue |
| txrdy_n | output | 1 | Active-low transmit-ready pin |
| rxrdy_n | output | 1 | Active-low receive-ready pin |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume several things about the inputs. Strobes are single-cycle and change only between clock edges. The default depth of 16 is a power of two that covers the highest trigger level of 14. No mode bit moves in the same cycle as a push it is meant to govern. The stimulus respects this by changing `fifo_en`, `dma_mode` and `trig_sel` only in cycles with no push or pop. Each strobe is raised for exactly one cycle by a task that always lowers it again. The bench never drives a pop on an empty receive queue except in the one test that checks it is dropped.

// File: rtl/hs_pkg.sv
// Package: shared helpers for the ready-pin/interrupt generator.
// Assumes trigger select is two bits wide.
package hs_pkg;
    // Map the two-bit trigger select onto its byte threshold.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/hs_fifo.sv
// Module: hs_fifo
// A circular queue with a live occupancy count. When cap_one is set, it
// accepts at most one entry, which makes it a holding register. Pushes
// beyond capacity and pops when empty are dropped. A flush empties it
// and takes priority over push and pop in the same cycle.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module hs_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       cap_one,
    input  logic                       wr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       rd,
    output logic [DATA_W-1:0]          rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cap;
    logic              do_wr, do_rd;

    // Work out the current capacity and which requests are accepted.
    always_comb begin
        cap   = cap_one ? CW'(1) : CW'(DEPTH);
        do_wr = wr && (count < cap);
        do_rd = rd && (count != '0);
    end

    // Move the pointers and the count, or clear everything on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end

    // Store accepted bytes; the storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/hs_ready_logic.sv
// Module: hs_ready_logic
// Turns the queue counts and the mode bits into the two active-low ready
// pins and the two interrupt requests. It keeps one latched flag for the
// DMA receive handshake. The flag is set at the trigger level or on a
// time-out and dropped when the queue is empty or DMA handshake is off.
// Assumes the counts come from registers, so the outputs are free of loops.
module hs_ready_logic #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       dma_mode,
    input  logic [1:0]                 trig_sel,
    input  logic                       rx_timeout,
    input  logic [$clog2(DEPTH+1)-1:0] tx_count,
    input  logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       txrdy_n,
    output logic                       rxrdy_n,
    output logic                       tx_irq,
    output logic                       rx_irq
);
    import hs_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic          blk_mode;
    logic          tx_empty, tx_full, rx_any, rx_at_trig;
    logic          rx_req_q, rx_req_d;
    logic [CW-1:0] trig;

    // Decode the fill state and the effective mode.
    always_comb begin
        trig       = CW'(trig_level(trig_sel));
        blk_mode   = fifo_en && dma_mode;
        tx_empty   = (tx_count == '0);
        tx_full    = (tx_count == CW'(DEPTH));
        rx_any     = (rx_count != '0);
        rx_at_trig = (rx_count >= trig);
        rx_req_d   = blk_mode && rx_any && (rx_req_q || rx_at_trig || rx_timeout);
    end

    // Hold the DMA receive handshake between trigger and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_req_q <= 1'b0;
        else        rx_req_q <= rx_req_d;
    end

    // Drive the pins and the interrupt requests according to the mode.
    always_comb begin
        tx_irq = tx_empty;
        if (blk_mode) begin
            txrdy_n = tx_full;
            rxrdy_n = !(rx_any && (rx_req_q || rx_at_trig));
        end else begin
            txrdy_n = !tx_empty;
            rxrdy_n = !rx_any;
        end
        rx_irq = fifo_en ? rx_at_trig : rx_any;
    end
endmodule

// File: rtl/uart_dma_handshake.sv
// Module: uart_dma_handshake (top)
// One serial channel's transmit and receive queues, together with the logic
// that makes the ready pins and the interrupt requests. Clearing fifo_en
// flushes both queues. The flush is detected from a registered copy of
// the enable bit.
// Assumes single-cycle strobes and a DEPTH that is a power of two, >= 14.
module uart_dma_handshake #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              dma_mode,
    input  logic [1:0]        trig_sel,
    input  logic              rx_timeout,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_rd,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_wr,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CW-1:0]     tx_count,
    output logic [CW-1:0]     rx_count,
    output logic              txrdy_n,
    output logic              rxrdy_n,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic fifo_en_q;
    logic flush;

    // Remember the previous enable bit so a falling edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_en_q <= 1'b0;
        else        fifo_en_q <= fifo_en;
    end

    assign flush = fifo_en_q && !fifo_en;

    hs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap_one(!fifo_en),
        .wr(tx_wr), .wdata(tx_wdata), .rd(tx_rd), .rdata(tx_rdata),
        .count(tx_count)
    );

    hs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap_one(!fifo_en),
        .wr(rx_wr), .wdata(rx_wdata), .rd(rx_rd), .rdata(rx_rdata),
        .count(rx_count)
    );

    hs_ready_logic #(.DEPTH(DEPTH)) u_rdy (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_sel(trig_sel), .rx_timeout(rx_timeout),
        .tx_count(tx_count), .rx_count(rx_count),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );
endmodule

// File: rtl/hs_checker.sv
// Module: hs_checker
// Temporal checks on the ports of uart_dma_handshake; bound to every instance.
module hs_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          tx_wr,
    input logic          tx_rd,
    input logic          rx_wr,
    input logic          rx_rd,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          txrdy_n,
    input logic          rxrdy_n,
    input logic          tx_irq,
    input logic          rx_irq
);
    // R11: a push into a full transmit queue leaves it full.
    assert_full_write_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && tx_wr && !tx_rd && tx_count == CW'(DEPTH)) |=> (tx_count == CW'(DEPTH)));

    // R11: a pop from an empty receive queue leaves it empty.
    assert_empty_read_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_wr && rx_count == '0) |=> (rx_count == '0));

    // R8: an empty transmit side always reports ready.
    assert_tx_empty_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> !txrdy_n);

    // R4: receive-ready never claims data that is not there.
    assert_rxrdy_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rxrdy_n |-> (rx_count != '0));

    // R9: reaching the trigger in queue mode always shows as ready.
    assert_trig_implies_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_irq) |-> !rxrdy_n);

    // R2: counts never exceed the queue depth.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));
endmodule

bind uart_dma_handshake hs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .tx_wr(tx_wr), .tx_rd(tx_rd), .rx_wr(rx_wr), .rx_rd(rx_rd),
    .tx_count(tx_count), .rx_count(rx_count),
    .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/tb_uart_dma_handshake.sv
module tb_uart_dma_handshake;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    // Trigger table: [5:4] select, [3:0] expected byte level.
    localparam logic [5:0] TRIG_VEC [4] = '{
        {2'd0, 4'd1}, {2'd1, 4'd4}, {2'd2, 4'd8}, {2'd3, 4'd14}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, dma_mode = 1'b0, rx_timeout = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       tx_wr = 1'b0, tx_rd = 1'b0, rx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic [7:0] tx_rdata, rx_rdata;
    logic [4:0] tx_count, rx_count;
    logic       txrdy_n, rxrdy_n, tx_irq, rx_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_dma_handshake dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_sel(trig_sel), .rx_timeout(rx_timeout),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd), .tx_rdata(tx_rdata),
        .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .tx_count(tx_count), .rx_count(rx_count),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives strobes across one rising edge.
    task automatic step(input logic twr, input logic trd, input logic rwr,
                        input logic rrd, input logic tmo, input logic [7:0] d);
        tx_wr = twr; tx_rd = trd; rx_wr = rwr; rx_rd = rrd; rx_timeout = tmo;
        tx_wdata = d; rx_wdata = d;
        @(negedge clk);
        tx_wr = 0; tx_rd = 0; rx_wr = 0; rx_rd = 0; rx_timeout = 0;
    endtask

    task automatic set_mode(input logic en, input logic dm, input logic [1:0] ts);
        fifo_en = en; dma_mode = dm; trig_sel = ts;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 tx_count", tx_count, 0);
        chk("R12 rx_count", rx_count, 0);
        chk("R12 txrdy_n", txrdy_n, 0);
        chk("R12 rxrdy_n", rxrdy_n, 1);
        chk("R12 tx_irq", tx_irq, 1);
        chk("R12 rx_irq", rx_irq, 0);

        // Trigger table walk in queue+DMA mode: R4, R9, R10, R12 order
        foreach (TRIG_VEC[v]) begin
            set_mode(1, 0, 2'd0);
            fifo_en = 0;
            @(negedge clk);
            chk("R10 flush rx_count", rx_count, 0);
            set_mode(1, 1, TRIG_VEC[v][5:4]);
            for (int n = 1; n <= DEPTH; n++) begin
                step(0, 0, 1, 0, 0, 8'(v * 32 + n));
                chk("R4 rxrdy_n on fill", rxrdy_n, (n >= int'(TRIG_VEC[v][3:0])) ? 0 : 1);
                chk("R9 rx_irq on fill", rx_irq, (n >= int'(TRIG_VEC[v][3:0])) ? 1 : 0);
            end
            for (int n = 1; n <= DEPTH; n++) begin
                chk("R12 rx order", rx_rdata, v * 32 + n);
                step(0, 0, 0, 1, 0, 8'h00);
                chk("R4 rxrdy_n held until drain", rxrdy_n, (n == DEPTH) ? 1 : 0);
                chk("R9 rx_irq on drain", rx_irq,
                    ((DEPTH - n) >= int'(TRIG_VEC[v][3:0])) ? 1 : 0);
            end
        end

        // Holding-register mode, DMA bit set but ignored: R1, R2, R8
        set_mode(0, 1, 2'd3);
        chk("R1 rxrdy_n empty", rxrdy_n, 1);
        step(0, 0, 1, 0, 0, 8'hA1);
        chk("R1 rxrdy_n held", rxrdy_n, 0);
        chk("R1 rx_irq held", rx_irq, 1);
        step(0, 0, 1, 0, 0, 8'hB2);
        chk("R1 second byte dropped", rx_count, 1);
        chk("R1 first byte kept", rx_rdata, 8'hA1);
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R1 rxrdy_n after read", rxrdy_n, 1);
        chk("R1 rx_irq after read", rx_irq, 0);
        step(1, 0, 0, 0, 0, 8'h5C);
        chk("R2 txrdy_n full", txrdy_n, 1);
        chk("R8 tx_irq held", tx_irq, 0);
        step(1, 0, 0, 0, 0, 8'h6D);
        chk("R2 second write dropped", tx_count, 1);
        chk("R2 data kept", tx_rdata, 8'h5C);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R2 txrdy_n empty", txrdy_n, 0);
        chk("R8 tx_irq empty", tx_irq, 1);

        // Queue mode without DMA: R3, R6, R9
        set_mode(1, 0, 2'd1);
        step(1, 0, 1, 0, 0, 8'h11);
        chk("R6 txrdy_n one byte", txrdy_n, 1);
        chk("R3 rxrdy_n one byte", rxrdy_n, 0);
        chk("R9 rx_irq below 4", rx_irq, 0);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R6 txrdy_n drained", txrdy_n, 0);

        // Queue mode with DMA, transmit side: R7, R11
        set_mode(1, 1, 2'd1);
        for (int n = 1; n < DEPTH; n++) step(1, 0, 0, 0, 0, 8'(n));
        chk("R7 txrdy_n at 15", txrdy_n, 0);
        chk("R8 tx_irq with data", tx_irq, 0);
        step(1, 0, 0, 0, 0, 8'hFF);
        chk("R7 txrdy_n full", txrdy_n, 1);
        step(1, 0, 0, 0, 0, 8'hEE);
        chk("R11 full write dropped", tx_count, DEPTH);

        // Flush from a loaded state: R10
        fifo_en = 0;
        @(negedge clk);
        chk("R10 tx_count flushed", tx_count, 0);
        chk("R10 rx_count flushed", rx_count, 0);
        chk("R10 rxrdy_n high", rxrdy_n, 1);

        // Time-out handshake: R5, R11
        set_mode(1, 1, 2'd3);
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R11 empty read dropped", rx_count, 0);
        step(0, 0, 0, 0, 1, 8'h00);
        chk("R5 timeout on empty ignored", rxrdy_n, 1);
        step(0, 0, 1, 0, 0, 8'h21);
        step(0, 0, 1, 0, 0, 8'h22);
        chk("R5 below trigger", rxrdy_n, 1);
        step(0, 0, 0, 0, 1, 8'h00);
        chk("R5 timeout asserts", rxrdy_n, 0);
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R5 held after one read", rxrdy_n, 0);
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R5 release at empty", rxrdy_n, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule